// File: doc/BRIEF.md
# Shared-Address ID-Matching I2C Target Selector

This block decides, byte by byte, whether one device among very many on a single I2C bus takes part in a transfer. Every device listens to the same write address and the same read address. It picks itself out by comparing a 32-bit identity that the controller sends as data against the value it was built with. It sits behind a byte-level bus front end, which reports bus conditions (START or repeated START, STOP), complete address bytes and complete received data bytes. For each address or data byte, the block returns an acknowledge decision on the following cycle. It also keeps a level-type "selected" indication and a read-enable indication, which downstream payload logic uses.

A write whose first data byte is 0xFF is a search command rather than a plain select. Four mask bytes and four identity bytes follow it. The device stays on the bus only if its identity agrees with the supplied identity in every bit that the mask sets. This lets a controller narrow down the identities that are present on the bus by binary search. Identities whose top byte is 0xFF are reserved, so a plain select never looks like a search. Multi-byte fields travel most significant byte first.

Top module: `idsel_target`

## Requirements
- R1: After reset, ack_vld, ack, selected and rd_en are low and no read permission is held, so a read to the read address is NACKed.
- R2: ack_vld is high for exactly the cycle after each address or data byte event, and low otherwise. ack is high (1 = ACK) only in such a cycle.
- R3: An address byte carries the address in bits [7:1] and R/W in bit 0 (1 = read). The write address with R/W = 0 is ACKed. Any address other than the write address (with R/W = 0) or the read address (with R/W = 1) is NACKed, and the data bytes that follow it are NACKed.
- R4: In a shared write, the first four data bytes are compared, in order, with identity bytes 31:24, 23:16, 15:8 and 7:0. Each matching byte is ACKed. Once all four match, selected goes high and read permission is granted.
- R5: On the first identity byte that does not match, that byte and every later byte up to the next START or STOP are NACKed, and selected stays low.
- R6: A read to the read address is ACKed, with selected and rd_en raised, only if the most recent shared write matched all four identity bytes. Otherwise it is NACKed.
- R7: Every shared write address byte clears read permission. A write that ends before the fourth identity byte, or that mismatches, therefore leaves no permission.
- R8: In a search command, the 0xFF byte, the four mask bytes and the first three search identity bytes are ACKed whatever their value.
- R9: The last search identity byte is ACKed, and selected goes high, only if (ID & mask) == (search ID & mask). Otherwise it is NACKed and later bytes are NACKed.
- R10: A successful search grants no read permission.
- R11: START or STOP drops selected and rd_en on the next cycle and rearms the block, so the next transaction is evaluated afresh.
- R12: While selected in a write, further payload bytes are ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP seen (one-cycle pulse) |
| ev_addr | input | 1 | rx_byte holds an address byte (one-cycle pulse) |
| ev_data | input | 1 | rx_byte holds a received data byte (one-cycle pulse) |
| rx_byte | input | 8 | Byte that accompanies ev_addr or ev_data |
| ack_vld | output | 1 | Acknowledge decision valid this cycle |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| selected | output | 1 | Device takes part in the current transaction |
| rd_en | output | 1 | Device is selected for a read |

## Verification
The bench builds the block with identity 0xA53C0F71, write address 0x2A and read address 0x2B. Because the four identity bytes are distinct, and none of them is 0x00 or 0xFF, a mismatch can be placed at any chosen byte position and still be told apart from a search opener. The masks used are full, top-byte-only and empty. With them, the bench reaches a search that succeeds only through masking, a search that fails on a single low bit, and a search that matches every device.

// File: rtl/idsel_pkg.sv
package idsel_pkg;
    localparam int ID_BYTES = 4;
    localparam int IDX_W    = $clog2(ID_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MATCH,
        ST_SMASK,
        ST_SID,
        ST_SEL_W,
        ST_SEL_R,
        ST_DROP
    } sel_state_e;
endpackage

// File: rtl/idsel_addr_dec.sv
module idsel_addr_dec #(
    parameter logic [6:0] WR_ADDR = 7'h2A,
    parameter logic [6:0] RD_ADDR = 7'h2B
) (
    input  logic [7:0] addr_byte,
    output logic       wr_hit,
    output logic       rd_hit
);
    always_comb begin
        wr_hit = (addr_byte[7:1] == WR_ADDR) && !addr_byte[0];
        rd_hit = (addr_byte[7:1] == RD_ADDR) &&  addr_byte[0];
    end
endmodule

// File: rtl/idsel_byte_cmp.sv
module idsel_byte_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] care,
    output logic         hit
);
    always_comb hit = ((a ^ b) & care) == '0;
endmodule

// File: rtl/idsel_target.sv
module idsel_target #(
    parameter logic [31:0] DEV_ID  = 32'hA53C_0F71,
    parameter logic [6:0]  WR_ADDR = 7'h2A,
    parameter logic [6:0]  RD_ADDR = 7'h2B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       ev_addr,
    input  logic       ev_data,
    input  logic [7:0] rx_byte,
    output logic       ack_vld,
    output logic       ack,
    output logic       selected,
    output logic       rd_en
);
    import idsel_pkg::*;

    localparam int IDW = 8 * ID_BYTES;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_BYTES - 1);

    typedef struct packed {
        sel_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [IDW-1:0]   mask;
        logic             match;
        logic             perm;
        logic             ack_vld;
        logic             ack;
    } regs_t;

    regs_t q, d;

    logic       wr_hit, rd_hit, byte_hit;
    logic [7:0] id_byte, care_byte;

    idsel_addr_dec #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_dec (
        .addr_byte(rx_byte),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    // Byte of the identity and of the mask at the current position, MSB first.
    always_comb begin
        id_byte   = DEV_ID[8*(ID_BYTES-1-int'(q.idx)) +: 8];
        care_byte = (q.state == ST_SID) ? q.mask[8*(ID_BYTES-1-int'(q.idx)) +: 8] : 8'hFF;
    end

    idsel_byte_cmp #(.W(8)) u_cmp (
        .a   (rx_byte),
        .b   (id_byte),
        .care(care_byte),
        .hit (byte_hit)
    );

    always_comb begin
        d         = q;
        d.ack_vld = 1'b0;
        d.ack     = 1'b0;
        if (ev_start || ev_stop) begin
            d.state = ST_IDLE;
            d.idx   = '0;
        end else if (ev_addr) begin
            d.ack_vld = 1'b1;
            d.idx     = '0;
            if (wr_hit) begin
                d.state = ST_MATCH;
                d.ack   = 1'b1;
                d.perm  = 1'b0;
                d.match = 1'b1;
            end else if (rd_hit && q.perm) begin
                d.state = ST_SEL_R;
                d.ack   = 1'b1;
            end else begin
                d.state = ST_DROP;
            end
        end else if (ev_data) begin
            d.ack_vld = 1'b1;
            unique case (q.state)
                ST_MATCH: begin
                    if (q.idx == '0 && rx_byte == 8'hFF) begin
                        d.state = ST_SMASK;
                        d.ack   = 1'b1;
                    end else if (byte_hit) begin
                        d.ack = 1'b1;
                        if (q.idx == LAST) begin
                            d.state = ST_SEL_W;
                            d.perm  = 1'b1;
                            d.idx   = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.state = ST_DROP;
                    end
                end
                ST_SMASK: begin
                    d.ack  = 1'b1;
                    d.mask = {q.mask[IDW-9:0], rx_byte};
                    if (q.idx == LAST) begin
                        d.state = ST_SID;
                        d.idx   = '0;
                        d.match = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_SID: begin
                    if (q.idx == LAST) begin
                        d.ack   = q.match && byte_hit;
                        d.state = (q.match && byte_hit) ? ST_SEL_W : ST_DROP;
                        d.idx   = '0;
                    end else begin
                        d.ack   = 1'b1;
                        d.match = q.match && byte_hit;
                        d.idx   = q.idx + 1'b1;
                    end
                end
                ST_SEL_W, ST_SEL_R: d.ack = 1'b1;
                default:            d.ack = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.idx     <= '0;
            q.mask    <= '0;
            q.match   <= 1'b0;
            q.perm    <= 1'b0;
            q.ack_vld <= 1'b0;
            q.ack     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ack_vld  = q.ack_vld;
    assign ack      = q.ack;
    assign selected = (q.state == ST_SEL_W) || (q.state == ST_SEL_R);
    assign rd_en    = (q.state == ST_SEL_R);

    // R2: a decision only follows a byte event
    a_r2_vld_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(ev_addr || ev_data));
    // R6: read enable can only appear on an address byte
    a_r6_rd_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(ev_addr));
    // R11: STOP always deselects
    a_r11_stop_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start) |=> (!selected && !rd_en));
    // R5: a dropped device NACKs data
    a_r5_drop_nacks: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DROP && ev_data && !ev_addr && !ev_start && !ev_stop) |=> !ack);
    // R10: read permission is granted only by a data byte
    a_r10_perm_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.perm) |-> $past(ev_data));
    // R4: becoming selected always comes with an ACK
    a_r4_sel_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> (ack && ack_vld));
endmodule

// File: tb/idsel_target_tb.sv
module idsel_target_tb;
    localparam logic [31:0] ID  = 32'hA53C_0F71;
    localparam logic [6:0]  WRA = 7'h2A;
    localparam logic [6:0]  RDA = 7'h2B;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_addr = 0, ev_data = 0;
    logic [7:0] rx_byte = '0;
    logic ack_vld, ack, selected, rd_en;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    idsel_target #(.DEV_ID(ID), .WR_ADDR(WRA), .RD_ADDR(RDA)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_addr(ev_addr), .ev_data(ev_data), .rx_byte(rx_byte),
        .ack_vld(ack_vld), .ack(ack), .selected(selected), .rd_en(rd_en)
    );

    // Behavioural reference model: 0 idle, 1 shared write, 2 read, 3 ignored
    int         m_mode = 0;
    bit         m_drop, m_perm, e_vld, e_ack, e_sel, e_rd;
    logic [7:0] bq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_drop = 0; m_perm = 0;
            e_vld = 0; e_ack = 0; e_sel = 0; e_rd = 0;
            bq.delete();
        end else if (ev_start || ev_stop) begin
            m_mode = 0; e_vld = 0; e_ack = 0; e_sel = 0; e_rd = 0;
        end else if (ev_addr) begin
            e_vld = 1; e_rd = 0;
            if (rx_byte[7:1] == WRA && !rx_byte[0]) begin
                m_mode = 1; m_drop = 0; m_perm = 0; bq.delete();
                e_ack = 1; e_sel = 0;
            end else if (rx_byte[7:1] == RDA && rx_byte[0] && m_perm) begin
                m_mode = 2; e_ack = 1; e_sel = 1; e_rd = 1;
            end else begin
                m_mode = 3; e_ack = 0; e_sel = 0;
            end
        end else if (ev_data) begin
            e_vld = 1;
            if (m_mode == 2) e_ack = 1;
            else if (m_mode == 1 && !m_drop) begin
                bq.push_back(rx_byte);
                if (bq[0] == 8'hFF) begin
                    if (bq.size() < 9) e_ack = 1;
                    else if (bq.size() == 9) begin
                        logic [31:0] mk, sid;
                        mk  = {bq[1], bq[2], bq[3], bq[4]};
                        sid = {bq[5], bq[6], bq[7], bq[8]};
                        if (((ID ^ sid) & mk) == 0) begin e_ack = 1; e_sel = 1; end
                        else begin e_ack = 0; m_drop = 1; end
                    end else e_ack = 1;
                end else if (bq.size() <= 4) begin
                    if (bq[bq.size()-1] == ID[8*(4-bq.size()) +: 8]) begin
                        e_ack = 1;
                        if (bq.size() == 4) begin e_sel = 1; m_perm = 1; end
                    end else begin e_ack = 0; m_drop = 1; end
                end else e_ack = 1;
            end else e_ack = 0;
        end else begin
            e_vld = 0; e_ack = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({ack_vld, ack, selected, rd_en} !== {e_vld, e_ack, e_sel, e_rd}) begin
                errors++;
                $display("FAIL %s vld/ack/sel/rd actual %b%b%b%b expected %b%b%b%b",
                         cur_req, ack_vld, ack, selected, rd_en, e_vld, e_ack, e_sel, e_rd);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(); @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0; endtask
    task automatic pulse_stop();  @(negedge clk) ev_stop = 1;  @(negedge clk) ev_stop = 0;  endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, input logic exp_ack, input string req);
        @(negedge clk) begin ev_addr = 1; rx_byte = {a, rw}; end
        @(negedge clk) ev_addr = 0;
        chk(req, ack, exp_ack, "addr ack");
    endtask

    task automatic send_data(input logic [7:0] b, input logic exp_ack, input string req);
        @(negedge clk) begin ev_data = 1; rx_byte = b; end
        @(negedge clk) ev_data = 0;
        chk(req, ack, exp_ack, "data ack");
        chk(req, ack_vld, 1'b1, "ack_vld");
    endtask

    task automatic full_select();
        pulse_start(); send_addr(WRA, 0, 1, "R3");
        send_data(8'hA5, 1, "R4"); send_data(8'h3C, 1, "R4");
        send_data(8'h0F, 1, "R4"); send_data(8'h71, 1, "R4");
        chk("R4", selected, 1'b1, "selected");
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", ack_vld, 1'b0, "ack_vld"); chk("R1", selected, 1'b0, "selected");
        chk("R1", rd_en, 1'b0, "rd_en");
        pulse_start(); send_addr(RDA, 1, 0, "R1"); pulse_stop();

        cur_req = "R3";
        pulse_start(); send_addr(7'h11, 0, 0, "R3"); send_data(8'hA5, 0, "R3");
        send_addr(WRA, 1, 0, "R3"); pulse_stop();

        cur_req = "R4";
        full_select();
        cur_req = "R12";
        send_data(8'h12, 1, "R12"); send_data(8'h00, 1, "R12");
        @(negedge clk); chk("R2", ack_vld, 1'b0, "ack_vld idle");
        cur_req = "R11";
        pulse_stop(); chk("R11", selected, 1'b0, "selected after stop");
        cur_req = "R6";
        pulse_start(); send_addr(RDA, 1, 1, "R6");
        chk("R6", rd_en, 1'b1, "rd_en"); chk("R6", selected, 1'b1, "selected");
        send_data(8'h55, 1, "R6");
        pulse_stop(); chk("R11", rd_en, 1'b0, "rd_en after stop");

        cur_req = "R5";
        pulse_start(); send_addr(WRA, 0, 1, "R5");
        send_data(8'hA5, 1, "R5"); send_data(8'h00, 0, "R5"); send_data(8'h0F, 0, "R5");
        send_data(8'h71, 0, "R5"); chk("R5", selected, 1'b0, "selected");
        pulse_stop();
        cur_req = "R7";
        pulse_start(); send_addr(RDA, 1, 0, "R7"); pulse_stop();
        full_select(); pulse_stop();
        pulse_start(); send_addr(WRA, 0, 1, "R7");
        send_data(8'hA5, 1, "R7"); send_data(8'h3C, 1, "R7"); pulse_stop();
        pulse_start(); send_addr(RDA, 1, 0, "R7"); pulse_stop();

        cur_req = "R8";
        full_select(); pulse_stop();
        pulse_start(); send_addr(WRA, 0, 1, "R8");
        send_data(8'hFF, 1, "R8");
        send_data(8'hFF, 1, "R8"); send_data(8'h00, 1, "R8");
        send_data(8'h00, 1, "R8"); send_data(8'h00, 1, "R8");
        send_data(8'hA5, 1, "R8"); send_data(8'h99, 1, "R8"); send_data(8'h99, 1, "R8");
        cur_req = "R9";
        send_data(8'h99, 1, "R9"); chk("R9", selected, 1'b1, "search selected");
        pulse_stop();
        cur_req = "R10";
        pulse_start(); send_addr(RDA, 1, 0, "R10"); pulse_stop();

        cur_req = "R9";
        pulse_start(); send_addr(WRA, 0, 1, "R9");
        send_data(8'hFF, 1, "R9");
        for (int i = 0; i < 4; i++) send_data(8'hFF, 1, "R8");
        send_data(8'hA5, 1, "R8"); send_data(8'h3C, 1, "R8"); send_data(8'h0F, 1, "R8");
        send_data(8'h70, 0, "R9"); send_data(8'h01, 0, "R9");
        chk("R9", selected, 1'b0, "search miss");
        cur_req = "R11";
        pulse_start(); send_addr(WRA, 0, 1, "R11");
        send_data(8'hFF, 1, "R11");
        for (int i = 0; i < 4; i++) send_data(8'h00, 1, "R11");
        for (int i = 0; i < 3; i++) send_data(8'h5A, 1, "R11");
        send_data(8'h5A, 1, "R11"); chk("R11", selected, 1'b1, "rearmed search");
        pulse_start(); full_select(); pulse_stop();

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule